// File: doc/BRIEF.md
# Interrupt Acknowledge Contention Arbiter

This block decides which of several interrupt-requesting sources answers an interrupt acknowledge cycle. Every source presents a 3-bit requested interrupt level and a 4-bit arbitration value. When an acknowledge begins, the arbiter captures the level decoded from the address bus. Only the sources whose pending level is non-zero and equal to that level become contenders. It also captures a snapshot of every arbitration value.

The contenders then settle the outcome bit-serially, most significant bit first, one bit per clock. In each bit cycle, every contender still in the running drives its bit onto a shared wired-OR line. A contender that drove 0 while the line reads 1 drops out. After the last bit, a one-cycle done strobe marks the result. The result is either a one-hot winner or a spurious flag. The spurious flag is raised when nobody took part or when the surviving value is zero. A duplicate flag is raised when more than one contender survived. The result is held until the next acknowledge is accepted. The vector fetch that follows and its bus timing belong to the surrounding logic.

Top module: `iack_contend`

## Requirements
- R1: A source takes part only when its requested level is non-zero and equal to `ackLevel` sampled with an accepted `ackStart`. Other sources never appear in `winnerOh`.
- R2: Among contenders, the one with the largest 4-bit arbitration value wins. `winnerOh` bit i (source i) is then the only bit set. A contender with value 0000 loses to any contender with a non-zero value.
- R3: `done` is high for exactly one cycle, after the 5th rising edge counted from the edge that sampled the accepted `ackStart` (one capture edge and then four bit edges, MSB first). `winnerOh`, `spurious` and `dupFlag` are valid from then on and are held until the next accepted start.
- R4: When no source takes part, `spurious` is 1 and `winnerOh` is 0 at `done`.
- R5: When the surviving arbitration value is 0000, `spurious` is 1 and `winnerOh` is 0.
- R6: When more than one contender survives all four bits (equal values), `dupFlag` is 1 and `winnerOh` is 0.
- R7: An `ackStart` pulse while a contention is in progress is ignored. The running contention completes on its original timing, with its original level.
- R8: Levels and arbitration values are captured at the accepted start. Changes to `srcLevel` or `srcPrio` during the contention have no effect on its result.
- R9: After reset, `winnerOh`, `spurious`, `dupFlag` and `done` are all 0.
- R10: On the edge that accepts `ackStart`, the held results are cleared. They read 0 until `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ackStart | input | 1 | Starts an acknowledge contention when the block is idle |
| ackLevel | input | 3 | Interrupt level decoded from the acknowledge address |
| srcLevel | input | 3*NUM_SRC | Requested level per source; source i uses bits [3i+2:3i], 0 = no request |
| srcPrio | input | 4*NUM_SRC | Arbitration value per source; source i uses bits [4i+3:4i] |
| winnerOh | output | NUM_SRC | One-hot winning source, 0 when there is none |
| spurious | output | 1 | No contender, or the winning value is zero |
| dupFlag | output | 1 | More than one contender survived |
| done | output | 1 | One-cycle strobe marking a valid result |

## Verification
The bench covers several corner cases, each paired with the error it would expose:
- Sources whose value differs from the leader's only in a low bit catch a drop-out rule that looks at the wrong bit or at the wrong cycle. Such a design names the wrong winner.
- A zero-valued contender, both alone and beside non-zero ones, separates a spurious outcome from a real loss.
- Equal values, both zero and non-zero, must raise the duplicate flag. They must not leave a stale or multi-hot winner.
- A stray start pulse mid-run, and source inputs rewritten mid-run, show whether the block restarts or re-samples when it should not. Either fault shows up as a shifted `done` or a different winner.

// File: rtl/iack_pkg.sv
package iack_pkg;
  // control strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture contenders and clear results
    logic resolve;  // one bit cycle of contention
    logic finish;   // last bit cycle: publish results
  } iackStrobes_t;
endpackage

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
#(
  parameter int PRIO_W = 4,
  localparam int CNT_W = $clog2(PRIO_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ackStart,
  output iackStrobes_t     strobes,
  output logic [CNT_W-1:0] bitIdx,
  output logic             done
);
  typedef enum logic {IDLE, RUN} ctrlState_t;

  ctrlState_t        state;
  logic [CNT_W-1:0]  bitCnt;

  always_comb begin
    strobes.load    = (state == IDLE) && ackStart;
    strobes.resolve = (state == RUN);
    strobes.finish  = (state == RUN) && (bitCnt == '0);
  end

  assign bitIdx = bitCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.load) begin
        state  <= RUN;
        bitCnt <= CNT_W'(PRIO_W - 1);
      end else if (state == RUN) begin
        if (bitCnt == '0) state <= IDLE;
        else              bitCnt <= bitCnt - 1'b1;
      end
    end
  end

  // R3: done is a single-cycle strobe
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: an accepted start begins at the MSB
  p_start_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (state == RUN) && (bitCnt == CNT_W'(PRIO_W - 1)));

  // R7: a run in progress keeps stepping down regardless of ackStart
  p_run_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && bitCnt != '0) |=> (state == RUN) && !strobes.load);
endmodule

// File: rtl/iack_datapath.sv
module iack_datapath
  import iack_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 4,
  parameter int LVL_W   = 3,
  localparam int CNT_W  = $clog2(PRIO_W),
  localparam int SC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  iackStrobes_t              strobes,
  input  logic [CNT_W-1:0]          bitIdx,
  input  logic [LVL_W-1:0]          ackLevel,
  input  logic [NUM_SRC*LVL_W-1:0]  srcLevel,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  output logic [NUM_SRC-1:0]        winnerOh,
  output logic                      spurious,
  output logic                      dupFlag
);
  logic [PRIO_W-1:0]  prioQ [NUM_SRC];
  logic [NUM_SRC-1:0] activeQ;
  logic [NUM_SRC-1:0] levelHit;
  logic [NUM_SRC-1:0] driveBit;
  logic [NUM_SRC-1:0] activeNext;
  logic               lineOr;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [LVL_W-1:0] lvl;
    assign lvl         = srcLevel[i*LVL_W +: LVL_W];
    assign levelHit[i] = (lvl != '0) && (lvl == ackLevel);
    assign driveBit[i] = activeQ[i] & prioQ[i][bitIdx];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            prioQ[i] <= '0;
      else if (strobes.load) prioQ[i] <= srcPrio[i*PRIO_W +: PRIO_W];
    end
  end

  // shared open-drain line modelled as wired-OR of active drivers
  assign lineOr = |driveBit;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      activeNext[i] = activeQ[i] & ~(lineOr & ~prioQ[i][bitIdx]);
  end

  // outcome evaluated from the survivors of the last bit
  logic [SC_W-1:0]   survCnt;
  logic [PRIO_W-1:0] survPrio;
  logic              resSpur, resDup;
  logic [NUM_SRC-1:0] resWin;

  always_comb begin
    survCnt  = '0;
    survPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      survCnt = survCnt + {{(SC_W-1){1'b0}}, activeNext[i]};
      if (activeNext[i]) survPrio = survPrio | prioQ[i];
    end
    resSpur = (survCnt == '0) || (survPrio == '0);
    resDup  = (survCnt > SC_W'(1));
    resWin  = (!resSpur && !resDup) ? activeNext : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ  <= '0;
      winnerOh <= '0;
      spurious <= 1'b0;
      dupFlag  <= 1'b0;
    end else if (strobes.load) begin
      activeQ  <= levelHit;
      winnerOh <= '0;
      spurious <= 1'b0;
      dupFlag  <= 1'b0;
    end else if (strobes.resolve) begin
      activeQ <= activeNext;
      if (strobes.finish) begin
        winnerOh <= resWin;
        spurious <= resSpur;
        dupFlag  <= resDup;
      end
    end
  end

  // R2: contention only ever removes contenders
  p_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.resolve && !strobes.load) |=> ((activeQ & ~$past(activeQ)) == '0));

  // R2: the winner indication is never multi-hot
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winnerOh));

  // R5: a spurious outcome names no winner
  p_spur_nowin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> (winnerOh == '0));

  // R6: a duplicate outcome names no winner
  p_dup_nowin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dupFlag |-> (winnerOh == '0));

  // R10: accepted start clears the held results
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (winnerOh == '0) && !spurious && !dupFlag);

  // R3: results hold between publication and the next start
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.finish) |=>
      $stable(winnerOh) && $stable(spurious) && $stable(dupFlag));
endmodule

// File: rtl/iack_contend.sv
module iack_contend
  import iack_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PRIO_W  = 4,
  parameter int LVL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ackStart,
  input  logic [LVL_W-1:0]          ackLevel,
  input  logic [NUM_SRC*LVL_W-1:0]  srcLevel,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  output logic [NUM_SRC-1:0]        winnerOh,
  output logic                      spurious,
  output logic                      dupFlag,
  output logic                      done
);
  localparam int CNT_W = $clog2(PRIO_W);

  iackStrobes_t     strobes;
  logic [CNT_W-1:0] bitIdx;

  iack_ctrl #(.PRIO_W(PRIO_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ackStart (ackStart),
    .strobes  (strobes),
    .bitIdx   (bitIdx),
    .done     (done)
  );

  iack_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .LVL_W(LVL_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .bitIdx   (bitIdx),
    .ackLevel (ackLevel),
    .srcLevel (srcLevel),
    .srcPrio  (srcPrio),
    .winnerOh (winnerOh),
    .spurious (spurious),
    .dupFlag  (dupFlag)
  );
endmodule

// File: tb/iack_contend_tb_top.sv
module iack_contend_tb_top;
  localparam int CLK_P = 10;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ackStart = 1'b0;
  logic [2:0] ackLevel = '0;
  logic [2:0] lvl [NS];
  logic [3:0] pri [NS];
  logic [NS*3-1:0] srcLevel;
  logic [NS*4-1:0] srcPrio;
  logic [NS-1:0] winnerOh;
  logic spurious, dupFlag, done;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      srcLevel[i*3 +: 3] = lvl[i];
      srcPrio[i*4 +: 4]  = pri[i];
    end
  end

  iack_contend dut_i (
    .clk(clk), .rst_n(rst_n), .ackStart(ackStart), .ackLevel(ackLevel),
    .srcLevel(srcLevel), .srcPrio(srcPrio), .winnerOh(winnerOh),
    .spurious(spurious), .dupFlag(dupFlag), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference outcome computed from the requirements
  task automatic model(input logic [2:0] lv, output int expW, output int eSp,
                       output int eDup);
    int best = -1;
    int cnt = 0;
    int who = 0;
    for (int i = 0; i < NS; i++) begin
      if (lvl[i] != 0 && lvl[i] == lv) begin
        if (int'(pri[i]) > best) begin best = int'(pri[i]); cnt = 1; who = i; end
        else if (int'(pri[i]) == best) cnt++;
      end
    end
    eSp  = (cnt == 0 || best == 0) ? 1 : 0;
    eDup = (cnt > 1) ? 1 : 0;
    expW = (cnt == 1 && best != 0) ? (1 << who) : 0;
  endtask

  task automatic setSrc(input int i, input logic [2:0] l, input logic [3:0] p);
    lvl[i] = l; pri[i] = p;
  endtask

  // mode 0 plain, 1 stray start mid-run (R7), 2 inputs rewritten mid-run (R8)
  task automatic runAck(input string tag, input logic [2:0] lv, input int mode);
    int eW, eS, eD;
    model(lv, eW, eS, eD);
    @(negedge clk);
    ackLevel = lv; ackStart = 1'b1;
    @(negedge clk);                 // capture edge passed
    ackStart = 1'b0;
    chk({tag, " R10 cleared win"}, int'(winnerOh), 0);
    chk({tag, " R10 cleared flags"}, int'({spurious, dupFlag}), 0);
    for (int k = 0; k < 3; k++) begin
      if (k == 0 && mode == 1) begin
        ackLevel = lv + 3'd1; ackStart = 1'b1;
      end
      if (k == 0 && mode == 2) begin
        for (int i = 0; i < NS; i++) begin pri[i] = ~pri[i]; lvl[i] = lv; end
      end
      @(negedge clk);
      ackStart = 1'b0;
      chk({tag, " R3 done not early"}, int'(done), 0);
    end
    @(negedge clk);
    chk({tag, " R3 done"}, int'(done), 1);
    chk({tag, " R2 winner"}, int'(winnerOh), eW);
    chk({tag, " R4 R5 spurious"}, int'(spurious), eS);
    chk({tag, " R6 dup"}, int'(dupFlag), eD);
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, int'(done), 0);
    chk({tag, " R3 winner held"}, int'(winnerOh), eW);
  endtask

  task automatic t_reset();
    chk("R9 reset win", int'(winnerOh), 0);
    chk("R9 reset flags", int'({spurious, dupFlag, done}), 0);
  endtask

  task automatic t_basic();  // R1 R2: close values, one off-level source
    setSrc(0, 3'd5, 4'b1010); setSrc(1, 3'd5, 4'b1011);
    setSrc(2, 3'd5, 4'b0111); setSrc(3, 3'd4, 4'b1111);
    runAck("basic", 3'd5, 0);
  endtask

  task automatic t_level();  // R1: only level 4 source competes
    runAck("level", 3'd4, 0);
  endtask

  task automatic t_nolevel(); // R1 R4: zero level never matches
    setSrc(0, 3'd0, 4'hF); setSrc(1, 3'd0, 4'hE);
    setSrc(2, 3'd2, 4'h3); setSrc(3, 3'd2, 4'h4);
    runAck("none", 3'd6, 0);
    runAck("ack0", 3'd0, 0);
  endtask

  task automatic t_zero();    // R5
    setSrc(0, 3'd3, 4'h0); setSrc(1, 3'd1, 4'h9);
    setSrc(2, 3'd1, 4'h0); setSrc(3, 3'd2, 4'h1);
    runAck("zero alone", 3'd3, 0);
    runAck("zero loses", 3'd1, 0);
  endtask

  task automatic t_dup();     // R6
    setSrc(0, 3'd7, 4'h6); setSrc(1, 3'd7, 4'h9);
    setSrc(2, 3'd7, 4'h9); setSrc(3, 3'd7, 4'h2);
    runAck("dup", 3'd7, 0);
    setSrc(1, 3'd2, 4'h0); setSrc(2, 3'd2, 4'h0);
    setSrc(0, 3'd1, 4'h1); setSrc(3, 3'd1, 4'h1);
    runAck("dup zero", 3'd2, 0);
  endtask

  task automatic t_stray();   // R7
    setSrc(0, 3'd4, 4'h1); setSrc(1, 3'd4, 4'h8);
    setSrc(2, 3'd5, 4'hF); setSrc(3, 3'd4, 4'h7);
    runAck("stray start", 3'd4, 1);
  endtask

  task automatic t_snap();    // R8
    setSrc(0, 3'd6, 4'hC); setSrc(1, 3'd6, 4'h3);
    setSrc(2, 3'd1, 4'h1); setSrc(3, 3'd6, 4'h5);
    runAck("snapshot", 3'd6, 2);
  endtask

  task automatic t_sweep();   // R2: each source in turn holds the top value
    for (int w = 0; w < NS; w++) begin
      for (int i = 0; i < NS; i++) setSrc(i, 3'd3, 4'(i + 1));
      setSrc(w, 3'd3, 4'hF);
      runAck("sweep", 3'd3, 0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin lvl[i] = '0; pri[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_level();
    t_nolevel();
    t_zero();
    t_dup();
    t_stray();
    t_snap();
    t_sweep();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule